// File: doc/BRIEF.md
# Machine-Mode Control and Status Register Unit

This unit holds the machine-mode control and status registers of a small 32-bit integer core that runs in machine mode only. Each CSR instruction is presented in one cycle: the CSR number, the operation (swap, bit-set or bit-clear), a source that is either a register value or a 5-bit immediate, and the 5-bit source field. One cycle later the unit returns the old value of the register and an illegal-instruction flag. Only a few fields are physically stored: the interrupt-enable and previous-enable bits, the previous-privilege field, the external-interrupt enable, the trap base address, a scratch word, the exception PC and the cause. Every other implemented register reads as zero.

The core also uses the unit for trap entry and trap return. On a trap it passes the PC and the cause. The unit saves the interrupt-enable state and shows the handler base and saved PC as continuous outputs. It also samples the external interrupt line and reports whether that interrupt is pending and enabled. Register numbers fall into three kinds. Some read as zero and trap when written. Some read as zero and drop writes. All other numbers trap on any access.

Top module: `mcsr_unit`

## Requirements
- R1: After synchronous reset, mstatus reads 0x0000_1800 (MIE=0, MPIE=0, MPP=3), mie, mscratch, mepc and mcause read 0, mtvec reads TVEC_RESET, and csr_valid, csr_illegal, csr_rdata and irq_pending are 0.
- R2: A request with csr_op 01 (swap), 10 (set bits) or 11 (clear bits) returns, in csr_rdata on the next cycle with csr_valid high, the register value before the request. The new value (source, old|source, or old&~source) is written at the same edge. The source is {27'b0, csr_fld} when csr_imm is 1 and csr_src otherwise.
- R3: A set-bits or clear-bits request whose csr_fld is 0 performs no write. Its legality is judged as for a read, so it is legal on the read-only identity registers.
- R4: mstatus (0x300) stores only bit 3 (MIE), bit 7 (MPIE) and bits 12:11 (MPP). mie (0x304) stores only bit 11 (MEIE). All other bits read as zero.
- R5: mtvec (0x305) stores bits 31:2, and bits 1:0 read as 00 (direct mode). trap_base always equals the mtvec value.
- R6: mip (0x344) bit 11 shows irq_ext as sampled at the previous clock edge. All other bits read zero, and writes to mip change nothing.
- R7: Registers 0xF11 to 0xF15 read as zero. Any request that writes one of them raises csr_illegal.
- R8: misa 0x301, mstatush 0x310, mcountinhibit 0x320, mtval 0x343, the counters 0xB00, 0xB02 and 0xB03 to 0xB1F, and the event selectors 0x323 to 0x33F read as zero and ignore writes without raising csr_illegal.
- R9: Every other CSR number, and csr_op 00, raises csr_illegal. An illegal request returns zero and changes no state.
- R10: On trap_req, MPIE takes the old MIE, MIE clears and MPP becomes 3. mepc takes trap_pc. mcause takes {trap_irq, zeros, trap_code}.
- R11: On mret_req without trap_req, MIE takes MPIE, MPIE becomes 1 and MPP becomes 3. mepc_out always shows mepc.
- R12: Priority is trap entry, then return, then the CSR write. A CSR write in the same cycle as either is dropped, but its read data and legality are still reported.
- R13: irq_pending is 1 exactly when the sampled irq_ext, MEIE and MIE are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_ext | input | 1 | External interrupt line |
| csr_req | input | 1 | CSR instruction this cycle |
| csr_op | input | 2 | 01 swap, 10 set bits, 11 clear bits, 00 illegal |
| csr_addr | input | 12 | CSR number |
| csr_imm | input | 1 | Take source from csr_fld |
| csr_fld | input | 5 | Source register index or immediate |
| csr_src | input | 32 | Source register value |
| trap_req | input | 1 | Trap entry this cycle |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_code | input | CODE_W | Exception or interrupt code |
| trap_pc | input | 32 | PC of the trapping instruction |
| mret_req | input | 1 | Trap return this cycle |
| csr_valid | output | 1 | Result of the previous cycle's request |
| csr_rdata | output | 32 | Old register value, zero if illegal |
| csr_illegal | output | 1 | Request raised illegal instruction |
| irq_pending | output | 1 | External interrupt pending and enabled |
| trap_base | output | 32 | Handler base address |
| mepc_out | output | 32 | Saved exception PC |

## Verification
A CSR write and trap entry (or return) can fall in the same cycle, and both touch mstatus. The bench drives a mscratch or mstatus write together with trap_req or mret_req, in directed steps and randomly. It then reads the registers back and compares them with a model in which the trap update wins and the write is dropped. The same steps check that the read data of the dropped write still shows the old value.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int XLEN = 32;
  localparam int AW   = 12;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SWAP = 2'b01,
    OP_SET  = 2'b10,
    OP_CLR  = 2'b11
  } csr_op_e;

  typedef enum logic [3:0] {
    K_STATUS, K_IE, K_TVEC, K_SCRATCH, K_EPC, K_CAUSE, K_IP,
    K_ZERO_WTRAP, K_ZERO_WIGN, K_BAD
  } csr_kind_e;

  localparam int MIE_BIT  = 3;
  localparam int MPIE_BIT = 7;
  localparam int MPP_LO   = 11;
  localparam int MPP_HI   = 12;
  localparam int MEXT_BIT = 11;

  localparam logic [AW-1:0] A_STATUS   = 12'h300;
  localparam logic [AW-1:0] A_ISA      = 12'h301;
  localparam logic [AW-1:0] A_IE       = 12'h304;
  localparam logic [AW-1:0] A_TVEC     = 12'h305;
  localparam logic [AW-1:0] A_STATUSH  = 12'h310;
  localparam logic [AW-1:0] A_CNTINH   = 12'h320;
  localparam logic [AW-1:0] A_EVT_LO   = 12'h323;
  localparam logic [AW-1:0] A_EVT_HI   = 12'h33F;
  localparam logic [AW-1:0] A_SCRATCH  = 12'h340;
  localparam logic [AW-1:0] A_EPC      = 12'h341;
  localparam logic [AW-1:0] A_CAUSE    = 12'h342;
  localparam logic [AW-1:0] A_TVAL     = 12'h343;
  localparam logic [AW-1:0] A_IP       = 12'h344;
  localparam logic [AW-1:0] A_CYC      = 12'hB00;
  localparam logic [AW-1:0] A_RET      = 12'hB02;
  localparam logic [AW-1:0] A_CTR_LO   = 12'hB03;
  localparam logic [AW-1:0] A_CTR_HI   = 12'hB1F;
  localparam logic [AW-1:0] A_ID_FIRST = 12'hF11;

  typedef struct packed {
    logic       mie;
    logic       mpie;
    logic [1:0] mpp;
    logic       meie;
    logic       meip;
  } mcsr_stat_t;
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
#(
  parameter int ID_COUNT = 5
) (
  input  logic [AW-1:0] addr,
  output csr_kind_e     kind
);
  logic [ID_COUNT-1:0] id_hit;

  for (genvar g = 0; g < ID_COUNT; g++) begin : g_id
    assign id_hit[g] = (addr == A_ID_FIRST + AW'(g));
  end

  logic ctr_hit, evt_hit;
  assign ctr_hit = (addr >= A_CTR_LO) && (addr <= A_CTR_HI);
  assign evt_hit = (addr >= A_EVT_LO) && (addr <= A_EVT_HI);

  always_comb begin
    case (addr)
      A_STATUS:  kind = K_STATUS;
      A_IE:      kind = K_IE;
      A_TVEC:    kind = K_TVEC;
      A_SCRATCH: kind = K_SCRATCH;
      A_EPC:     kind = K_EPC;
      A_CAUSE:   kind = K_CAUSE;
      A_IP:      kind = K_IP;
      A_ISA, A_STATUSH, A_CNTINH, A_TVAL, A_CYC, A_RET:
                 kind = K_ZERO_WIGN;
      default: begin
        if (|id_hit)                kind = K_ZERO_WTRAP;
        else if (ctr_hit | evt_hit) kind = K_ZERO_WIGN;
        else                        kind = K_BAD;
      end
    endcase
  end
endmodule

// File: rtl/mcsr_rmw.sv
module mcsr_rmw
  import mcsr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] src_val,
  input  logic         src_zero,
  output logic [W-1:0] new_val,
  output logic         wr_intent,
  output logic         op_bad
);
  always_comb begin
    new_val   = old_val;
    wr_intent = 1'b0;
    op_bad    = 1'b0;
    case (csr_op_e'(op))
      OP_SWAP: begin new_val = src_val;            wr_intent = 1'b1;      end
      OP_SET:  begin new_val = old_val | src_val;  wr_intent = !src_zero; end
      OP_CLR:  begin new_val = old_val & ~src_val; wr_intent = !src_zero; end
      default: op_bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/mcsr_state.sv
module mcsr_state
  import mcsr_pkg::*;
#(
  parameter int              CODE_W     = 4,
  parameter logic [XLEN-1:0] TVEC_RESET = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_ext,
  input  csr_kind_e         kind,
  input  logic              csr_we,
  input  logic [XLEN-1:0]   wr_val,
  input  logic              trap_req,
  input  logic              trap_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic              mret_req,
  output logic [XLEN-1:0]   rd_val,
  output mcsr_stat_t        stat,
  output logic [XLEN-1:0]   tvec_val,
  output logic [XLEN-1:0]   epc_val
);
  localparam int PAD_W = XLEN - 1 - CODE_W;

  logic              mie_q, mpie_q, meie_q, irq_q;
  logic [1:0]        mpp_q;
  logic [XLEN-1:2]   tvec_q;
  logic [XLEN-1:0]   scratch_q, epc_q, cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mie_q     <= 1'b0;
      mpie_q    <= 1'b0;
      mpp_q     <= 2'b11;
      meie_q    <= 1'b0;
      irq_q     <= 1'b0;
      tvec_q    <= TVEC_RESET[XLEN-1:2];
      scratch_q <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
    end else begin
      irq_q <= irq_ext;
      if (trap_req) begin
        mpie_q  <= mie_q;
        mie_q   <= 1'b0;
        mpp_q   <= 2'b11;
        epc_q   <= trap_pc;
        cause_q <= {trap_irq, {PAD_W{1'b0}}, trap_code};
      end else if (mret_req) begin
        mie_q  <= mpie_q;
        mpie_q <= 1'b1;
        mpp_q  <= 2'b11;
      end else if (csr_we) begin
        case (kind)
          K_STATUS: begin
            mie_q  <= wr_val[MIE_BIT];
            mpie_q <= wr_val[MPIE_BIT];
            mpp_q  <= wr_val[MPP_HI:MPP_LO];
          end
          K_IE:      meie_q    <= wr_val[MEXT_BIT];
          K_TVEC:    tvec_q    <= wr_val[XLEN-1:2];
          K_SCRATCH: scratch_q <= wr_val;
          K_EPC:     epc_q     <= wr_val;
          K_CAUSE:   cause_q   <= wr_val;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (kind)
      K_STATUS: begin
        rd_val[MIE_BIT]       = mie_q;
        rd_val[MPIE_BIT]      = mpie_q;
        rd_val[MPP_HI:MPP_LO] = mpp_q;
      end
      K_IE:      rd_val[MEXT_BIT] = meie_q;
      K_IP:      rd_val[MEXT_BIT] = irq_q;
      K_TVEC:    rd_val = {tvec_q, 2'b00};
      K_SCRATCH: rd_val = scratch_q;
      K_EPC:     rd_val = epc_q;
      K_CAUSE:   rd_val = cause_q;
      default:   rd_val = '0;
    endcase
  end

  assign stat     = '{mie: mie_q, mpie: mpie_q, mpp: mpp_q, meie: meie_q, meip: irq_q};
  assign tvec_val = {tvec_q, 2'b00};
  assign epc_val  = epc_q;
endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
#(
  parameter int          CODE_W     = 4,
  parameter logic [31:0] TVEC_RESET = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_ext,
  input  logic              csr_req,
  input  logic [1:0]        csr_op,
  input  logic [11:0]       csr_addr,
  input  logic              csr_imm,
  input  logic [4:0]        csr_fld,
  input  logic [31:0]       csr_src,
  input  logic              trap_req,
  input  logic              trap_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [31:0]       trap_pc,
  input  logic              mret_req,
  output logic              csr_valid,
  output logic [31:0]       csr_rdata,
  output logic              csr_illegal,
  output logic              irq_pending,
  output logic [31:0]       trap_base,
  output logic [31:0]       mepc_out
);
  localparam int FLD_PAD = XLEN - 5;

  csr_kind_e       kind;
  mcsr_stat_t      stat;
  logic [XLEN-1:0] rd_val, src_val, new_val;
  logic            wr_intent, op_bad, bad_access, csr_we;

  mcsr_decode #(.ID_COUNT(5)) u_dec (
    .addr (csr_addr),
    .kind (kind)
  );

  assign src_val = csr_imm ? {{FLD_PAD{1'b0}}, csr_fld} : csr_src;

  mcsr_rmw #(.W(XLEN)) u_rmw (
    .old_val   (rd_val),
    .op        (csr_op),
    .src_val   (src_val),
    .src_zero  (csr_fld == 5'd0),
    .new_val   (new_val),
    .wr_intent (wr_intent),
    .op_bad    (op_bad)
  );

  assign bad_access = op_bad || (kind == K_BAD) || ((kind == K_ZERO_WTRAP) && wr_intent);
  assign csr_we     = csr_req && wr_intent && !bad_access && !trap_req && !mret_req;

  mcsr_state #(.CODE_W(CODE_W), .TVEC_RESET(TVEC_RESET)) u_state (
    .clk       (clk),
    .rst       (rst),
    .irq_ext   (irq_ext),
    .kind      (kind),
    .csr_we    (csr_we),
    .wr_val    (new_val),
    .trap_req  (trap_req),
    .trap_irq  (trap_irq),
    .trap_code (trap_code),
    .trap_pc   (trap_pc),
    .mret_req  (mret_req),
    .rd_val    (rd_val),
    .stat      (stat),
    .tvec_val  (trap_base),
    .epc_val   (mepc_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_valid   <= 1'b0;
      csr_illegal <= 1'b0;
      csr_rdata   <= '0;
    end else begin
      csr_valid   <= csr_req;
      csr_illegal <= csr_req && bad_access;
      csr_rdata   <= (csr_req && !bad_access) ? rd_val : '0;
    end
  end

  assign irq_pending = stat.meip && stat.meie && stat.mie;
endmodule

// File: rtl/mcsr_unit_chk.sv
module mcsr_unit_chk
  import mcsr_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        irq_ext,
  input logic        csr_req,
  input logic [1:0]  csr_op,
  input logic [11:0] csr_addr,
  input logic        trap_req,
  input logic [31:0] trap_pc,
  input logic        mret_req,
  input logic        csr_valid,
  input logic [31:0] csr_rdata,
  input logic        csr_illegal,
  input logic        irq_pending,
  input logic [31:0] mepc_out,
  input mcsr_stat_t  stat
);
  assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    csr_valid == $past(csr_req));

  assert_id_write_traps_R7: assert property (@(posedge clk) disable iff (rst)
    (csr_req && csr_op == 2'b01 && csr_addr >= 12'hF11 && csr_addr <= 12'hF15) |=> csr_illegal);

  assert_illegal_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    csr_illegal |-> (csr_rdata == 32'h0));

  assert_trap_status_R10: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> (!stat.mie && stat.mpie == $past(stat.mie) && stat.mpp == 2'b11));

  assert_trap_epc_R10: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> (mepc_out == $past(trap_pc)));

  assert_mret_status_R11: assert property (@(posedge clk) disable iff (rst)
    (mret_req && !trap_req) |=> (stat.mie == $past(stat.mpie) && stat.mpie));

  assert_pending_needs_line_R13: assert property (@(posedge clk) disable iff (rst)
    irq_pending |-> $past(irq_ext));
endmodule

bind mcsr_unit mcsr_unit_chk u_chk (.*);

// File: tb/sim_mcsr_unit.sv
module sim_mcsr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_ext = 1'b0;
  logic        csr_req = 1'b0;
  logic [1:0]  csr_op = 2'b00;
  logic [11:0] csr_addr = 12'h0;
  logic        csr_imm = 1'b0;
  logic [4:0]  csr_fld = 5'd0;
  logic [31:0] csr_src = 32'h0;
  logic        trap_req = 1'b0;
  logic        trap_irq = 1'b0;
  logic [3:0]  trap_code = 4'd0;
  logic [31:0] trap_pc = 32'h0;
  logic        mret_req = 1'b0;
  logic        csr_valid, csr_illegal, irq_pending;
  logic [31:0] csr_rdata, trap_base, mepc_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mcsr_unit #(.CODE_W(4), .TVEC_RESET(32'h0)) u0 (.*);

  // model state
  logic        m_mie = 0, m_mpie = 0, m_meie = 0, m_irq = 0;
  logic [1:0]  m_mpp = 2'b11;
  logic [29:0] m_tvec = '0;
  logic [31:0] m_scr = 0, m_epc = 0, m_cause = 0;

  // 0 bad, 1 zero trap-on-write, 2 zero write-ignored, 3 stored
  function automatic int kind_of(input logic [11:0] a);
    if (a == 12'h300 || a == 12'h304 || a == 12'h305 || a == 12'h340 ||
        a == 12'h341 || a == 12'h342 || a == 12'h344) return 3;
    if (a >= 12'hF11 && a <= 12'hF15) return 1;
    if (a == 12'h301 || a == 12'h310 || a == 12'h320 || a == 12'h343 ||
        a == 12'hB00 || a == 12'hB02) return 2;
    if ((a >= 12'hB03 && a <= 12'hB1F) || (a >= 12'h323 && a <= 12'h33F)) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h300: return (32'(m_mpp) << 11) | (32'(m_mpie) << 7) | (32'(m_mie) << 3);
      12'h304: return 32'(m_meie) << 11;
      12'h305: return {m_tvec, 2'b00};
      12'h340: return m_scr;
      12'h341: return m_epc;
      12'h342: return m_cause;
      12'h344: return 32'(m_irq) << 11;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(input logic [11:0] a, input logic [31:0] v);
    case (a)
      12'h300: begin m_mie = v[3]; m_mpie = v[7]; m_mpp = v[12:11]; end
      12'h304: m_meie = v[11];
      12'h305: m_tvec = v[31:2];
      12'h340: m_scr = v;
      12'h341: m_epc = v;
      12'h342: m_cause = v;
      default: ;
    endcase
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check at next negedge
  task automatic step(input string tag, input logic req, input logic [1:0] op,
                      input logic [11:0] a, input logic imm, input logic [4:0] fld,
                      input logic [31:0] rv, input logic trp, input logic ti,
                      input logic [3:0] tc, input logic [31:0] tpc,
                      input logic mr, input logic irq);
    logic        wr, ill;
    logic [31:0] oldv, src, nv, exp_rd;
    int          k;
    csr_req = req; csr_op = op; csr_addr = a; csr_imm = imm; csr_fld = fld;
    csr_src = rv; trap_req = trp; trap_irq = ti; trap_code = tc; trap_pc = tpc;
    mret_req = mr; irq_ext = irq;
    k    = kind_of(a);
    wr   = (op == 2'b01) || (op != 2'b00 && fld != 5'd0);
    ill  = (op == 2'b00) || (k == 0) || (k == 1 && wr);
    oldv = m_read(a);
    exp_rd = ill ? 32'h0 : oldv;
    src  = imm ? {27'b0, fld} : rv;
    nv   = (op == 2'b01) ? src : (op == 2'b10) ? (oldv | src) : (oldv & ~src);
    if (trp) begin
      m_mpie = m_mie; m_mie = 1'b0; m_mpp = 2'b11; m_epc = tpc;
      m_cause = {ti, 27'b0, tc};
    end else if (mr) begin
      m_mie = m_mpie; m_mpie = 1'b1; m_mpp = 2'b11;
    end else if (req && wr && !ill) begin
      m_write(a, nv);
    end
    m_irq = irq;
    @(negedge clk);
    chk(csr_valid == req, "R2 valid", 32'(csr_valid), 32'(req));
    if (req) begin
      chk(csr_illegal == ill, {tag, " illegal"}, 32'(csr_illegal), 32'(ill));
      chk(csr_rdata == exp_rd, {tag, " rdata"}, csr_rdata, exp_rd);
    end
    chk(trap_base == {m_tvec, 2'b00}, "R5 trap_base", trap_base, {m_tvec, 2'b00});
    chk(mepc_out == m_epc, "R11 mepc_out", mepc_out, m_epc);
    chk(irq_pending == (m_irq & m_meie & m_mie), "R13 irq_pending",
        32'(irq_pending), 32'(m_irq & m_meie & m_mie));
  endtask

  task automatic csr(input string tag, input logic [1:0] op, input logic [11:0] a,
                     input logic [4:0] fld, input logic [31:0] rv);
    step(tag, 1'b1, op, a, 1'b0, fld, rv, 1'b0, 1'b0, 4'd0, 32'h0, 1'b0, irq_ext);
  endtask

  task automatic rd_expect(input string tag, input logic [11:0] a, input logic [31:0] v);
    csr(tag, 2'b10, a, 5'd0, 32'h0);
    chk(csr_rdata == v, {tag, " value"}, csr_rdata, v);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R0 watchdog expired");
    summary();
  end

  initial begin
    logic [11:0] pool [0:15];
    void'($urandom(32'd20240517));
    pool[0] = 12'h300; pool[1] = 12'h304; pool[2] = 12'h305; pool[3] = 12'h340;
    pool[4] = 12'h341; pool[5] = 12'h342; pool[6] = 12'h344; pool[7] = 12'hF12;
    pool[8] = 12'hF15; pool[9] = 12'h301; pool[10] = 12'hB10; pool[11] = 12'h33F;
    pool[12] = 12'h302; pool[13] = 12'h30A; pool[14] = 12'hB80; pool[15] = 12'h747;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(csr_valid == 0 && csr_illegal == 0 && csr_rdata == 0, "R1 outputs", csr_rdata, 32'h0);
    chk(irq_pending == 0, "R1 pending", 32'(irq_pending), 32'h0);
    chk(trap_base == 32'h0 && mepc_out == 32'h0, "R1 base/epc", trap_base, 32'h0);
    rd_expect("R1 mstatus", 12'h300, 32'h0000_1800);
    rd_expect("R1 mcause", 12'h342, 32'h0);

    // R4 stored bits only
    csr("R4", 2'b01, 12'h300, 5'd1, 32'hFFFF_FFFF);
    rd_expect("R4 mstatus", 12'h300, 32'h0000_1888);
    csr("R4", 2'b01, 12'h304, 5'd1, 32'hFFFF_FFFF);
    rd_expect("R4 mie", 12'h304, 32'h0000_0800);
    csr("R2 clr", 2'b11, 12'h300, 5'd1, 32'h0000_0008);
    rd_expect("R2 clr result", 12'h300, 32'h0000_1880);
    step("R2 imm", 1'b1, 2'b10, 12'h340, 1'b1, 5'd21, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    rd_expect("R2 imm result", 12'h340, 32'h0000_0015);

    // R5 mtvec
    csr("R5", 2'b01, 12'h305, 5'd1, 32'hFFFF_FFFF);
    rd_expect("R5 mtvec", 12'h305, 32'hFFFF_FFFC);

    // R6 mip
    step("R6", 1'b0, 2'b00, 12'h0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b1);
    rd_expect("R6 mip", 12'h344, 32'h0000_0800);
    csr("R6 write", 2'b01, 12'h344, 5'd1, 32'h0);
    rd_expect("R6 mip after write", 12'h344, 32'h0000_0800);

    // R7 / R3 identity registers
    csr("R7 swap", 2'b01, 12'hF11, 5'd0, 32'h1234);
    chk(csr_illegal == 1'b1, "R7 illegal", 32'(csr_illegal), 32'h1);
    csr("R3 set x0", 2'b10, 12'hF14, 5'd0, 32'hFFFF);
    chk(csr_illegal == 1'b0, "R3 legal", 32'(csr_illegal), 32'h0);
    csr("R7 clr", 2'b11, 12'hF13, 5'd3, 32'hFFFF);
    csr("R3 scratch no write", 2'b10, 12'h340, 5'd0, 32'hFFFF_FFFF);
    rd_expect("R3 scratch kept", 12'h340, 32'h0000_0015);

    // R8 write-ignored group
    csr("R8 misa", 2'b01, 12'h301, 5'd1, 32'hFFFF_FFFF);
    chk(csr_illegal == 1'b0, "R8 legal", 32'(csr_illegal), 32'h0);
    rd_expect("R8 misa", 12'h301, 32'h0);
    csr("R8 event", 2'b01, 12'h33F, 5'd1, 32'h55);

    // R9 unimplemented and bad op
    csr("R9 deleg", 2'b10, 12'h302, 5'd0, 32'h0);
    chk(csr_illegal == 1'b1, "R9 illegal", 32'(csr_illegal), 32'h1);
    csr("R9 op00", 2'b00, 12'h340, 5'd1, 32'hDEAD_BEEF);
    rd_expect("R9 scratch kept", 12'h340, 32'h0000_0015);

    // R13 pending: MIE set, MEIE set, irq high
    csr("R13", 2'b10, 12'h300, 5'd1, 32'h8);
    chk(irq_pending == 1'b1, "R13 pending set", 32'(irq_pending), 32'h1);

    // R10 trap entry
    step("R10", 0, 0, 0, 0, 0, 0, 1'b1, 1'b1, 4'd11, 32'h0000_0400, 0, 1'b1);
    chk(irq_pending == 1'b0, "R10 pending masked", 32'(irq_pending), 32'h0);
    rd_expect("R10 mcause", 12'h342, 32'h8000_000B);
    rd_expect("R10 mstatus", 12'h300, 32'h0000_1880);

    // R11 return
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b1, 1'b0);
    rd_expect("R11 mstatus", 12'h300, 32'h0000_1888);

    // R12 same-cycle trap and write
    step("R12", 1'b1, 2'b01, 12'h340, 0, 5'd1, 32'hCAFE_0000, 1'b1, 1'b0, 4'd2, 32'h88, 0, 0);
    rd_expect("R12 scratch kept", 12'h340, 32'h0000_0015);
    step("R12 mret", 1'b1, 2'b01, 12'h300, 0, 5'd1, 32'h0, 0, 0, 0, 0, 1'b1, 0);
    rd_expect("R12 mstatus after mret", 12'h300, 32'h0000_1888);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [4:0]  f;
      a = ($urandom % 8 == 0) ? 12'($urandom) : pool[$urandom % 16];
      f = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
      step("R2 random", 1'($urandom % 4 != 0), 2'($urandom), a, 1'($urandom),
           f, $urandom, 1'($urandom % 10 == 0), 1'($urandom), 4'($urandom),
           $urandom, 1'($urandom % 10 == 0), 1'($urandom));
    end
    summary();
  end
endmodule